// File: doc/BRIEF.md
# Dual-Lane Key-Add and Substitution Byte Path with Correlated Noise Lane

This block computes the first-round byte operation of a block cipher. It XORs one input byte with an 8-bit secret key and then passes the result through the forward AES substitution box. The result is registered and sent downstream with a valid strobe one cycle after the input strobe.

To hide the power signature of the secret-key lane, the same input byte is also sent, in the same cycle, to a second lane of identical structure. That lane uses its own 8-bit interfering key. It registers its substitution result on the same clock edge as the main lane, but nothing reads that register. Its switching therefore follows the data and adds activity that is correlated with the data, but not with the secret key alone.

Both keys are captured together on a load strobe and hold their values while data flows. If the two keys are equal, the protection is void. In that case the block raises a clash flag and blocks all output. An asynchronous active-low reset is released through a synchronizer before the registers leave reset.

Top module: `cpng_byte_path`

## Requirements
- R1: After reset both keys are zero, `dout` is 0x00, `dout_valid` is low and `key_clash` is high, because the two keys are equal.
- R2: A high `key_load` at a clock edge captures `key_main_in` and `key_noise_in` together. A byte accepted at that same edge still uses the previous keys. Bytes accepted at later edges use the new keys. Without `key_load` the keys do not change.
- R3: When `din_valid` is high and `key_clash` is low at an edge, `dout` equals SBOX(`din` XOR main key) and `dout_valid` is high after that edge. SBOX is the forward AES substitution, with SBOX(0x00)=0x63 and SBOX(0x53)=0xED.
- R4: When `din_valid` is low at an edge, `dout_valid` is low after it and `dout` keeps its value.
- R5: `key_clash` is high exactly when the two stored keys are equal. While it is high, accepted bytes are dropped: `dout_valid` stays low and `dout` keeps its value.
- R6: The noise lane captures SBOX(`din` XOR noise key) on the same edge as the main lane, and only on edges where the main lane captures. Its value never reaches any output, so `dout` does not depend on the noise key.
- R7: Any noise-key value from 0x00 to 0xFF that differs from the main key is accepted, including both extremes, and gives a normal main-lane result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | Captures both key inputs at the edge |
| key_main_in | input | 8 | Secret key value to load |
| key_noise_in | input | 8 | Interfering key value to load |
| din_valid | input | 1 | Input byte qualifier |
| din | input | 8 | Input byte fed to both lanes |
| dout_valid | output | 1 | Registered result is new |
| dout | output | 8 | Main-lane substitution result |
| key_clash | output | 1 | Stored keys are equal; output blocked |

## Verification
A byte presented with `din_valid` is registered at the next rising edge. Its `dout` and `dout_valid` are due right after that edge. Inputs change on falling edges, and each check samples on the falling edge that follows the capturing edge, which is exactly one register later. A key load takes effect at its edge, so `key_clash` is checked at the falling edge after the load. A byte sent together with the load is checked against the old key in that same window. The noise lane has no port, so its lockstep capture is covered by properties in the bound checker, and its isolation from the output is checked at `dout` across different noise keys.

// File: rtl/cpng_pkg.sv
package cpng_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[BYTE_W-1] ? ((sh << 1) ^ 8'h1b) : (sh << 1);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254 by square and multiply (0 maps to 0)
  function automatic byte_t gf_inv(input byte_t x);
    byte_t r;
    byte_t p;
    r = 8'h01;
    p = x;
    for (int i = 0; i < BYTE_W; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t sbox_fwd(input byte_t x);
    byte_t v;
    byte_t s;
    v = gf_inv(x);
    for (int i = 0; i < BYTE_W; i++) begin
      s[i] = v[i] ^ v[(i+4)%BYTE_W] ^ v[(i+5)%BYTE_W] ^ v[(i+6)%BYTE_W]
           ^ v[(i+7)%BYTE_W];
    end
    return s ^ 8'h63;
  endfunction
endpackage

// File: rtl/cpng_rst_sync.sv
module cpng_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else        chain_q[g] <= (g == 0) ? 1'b1 : chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cpng_key_bank.sv
module cpng_key_bank
  import cpng_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t main_in,
  input  byte_t noise_in,
  output byte_t main_q,
  output byte_t noise_q,
  output logic  equal
);
  byte_t main_nxt;
  byte_t noise_nxt;

  always_comb begin
    main_nxt  = main_q;
    noise_nxt = noise_q;
    if (load) begin
      main_nxt  = main_in;
      noise_nxt = noise_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q  <= '0;
      noise_q <= '0;
    end else begin
      main_q  <= main_nxt;
      noise_q <= noise_nxt;
    end
  end

  assign equal = (main_q == noise_q);
endmodule

// File: rtl/cpng_sub_lane.sv
module cpng_sub_lane
  import cpng_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  byte_t din,
  input  byte_t key,
  output byte_t q
);
  byte_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = sbox_fwd(din ^ key);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/cpng_byte_path.sv
module cpng_byte_path
  import cpng_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_load,
  input  logic [7:0] key_main_in,
  input  logic [7:0] key_noise_in,
  input  logic       din_valid,
  input  logic [7:0] din,
  output logic       dout_valid,
  output logic [7:0] dout,
  output logic       key_clash
);
  logic  rst_q_n;
  byte_t key_main_q;
  byte_t key_noise_q;
  byte_t noise_unused_q;
  logic  accept;
  logic  vld_nxt;

  cpng_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  cpng_key_bank u_keys (
    .clk(clk), .rst_n(rst_q_n), .load(key_load),
    .main_in(key_main_in), .noise_in(key_noise_in),
    .main_q(key_main_q), .noise_q(key_noise_q), .equal(key_clash)
  );

  assign accept = din_valid & ~key_clash;

  // main lane: the only consumer of its register is the output
  cpng_sub_lane u_main (
    .clk(clk), .rst_n(rst_q_n), .en(accept),
    .din(din), .key(key_main_q), .q(dout)
  );

  // noise lane: same data, same enable, its own key; result has no fanout
  cpng_sub_lane u_noise (
    .clk(clk), .rst_n(rst_q_n), .en(accept),
    .din(din), .key(key_noise_q), .q(noise_unused_q)
  );

  always_comb vld_nxt = accept;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) dout_valid <= 1'b0;
    else          dout_valid <= vld_nxt;
  end
endmodule

// File: rtl/cpng_byte_path_chk.sv
module cpng_byte_path_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       key_load,
  input logic       din_valid,
  input logic       dout_valid,
  input logic [7:0] dout,
  input logic       key_clash,
  input logic [7:0] km,
  input logic [7:0] kn,
  input logic [7:0] noise_q
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> ($past(din_valid) && !$past(key_clash)));  // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> $stable(dout));  // R4
  AST_CLASH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    key_clash |=> !dout_valid);  // R5
  AST_KEYS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(key_load) |-> ($stable(km) && $stable(kn)));  // R2
  AST_NOISE_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(noise_q) |-> dout_valid);  // R6
endmodule

bind cpng_byte_path cpng_byte_path_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .key_load(key_load), .din_valid(din_valid),
  .dout_valid(dout_valid), .dout(dout), .key_clash(key_clash),
  .km(key_main_q), .kn(key_noise_q), .noise_q(noise_unused_q)
);

// File: tb/cpng_byte_path_bench.sv
module cpng_byte_path_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_load = 1'b0;
  logic [7:0] key_main_in = '0;
  logic [7:0] key_noise_in = '0;
  logic       din_valid = 1'b0;
  logic [7:0] din = '0;
  logic       dout_valid;
  logic [7:0] dout;
  logic       key_clash;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpng_byte_path u_cpng_byte_path (
    .clk(clk), .rst_n(rst_n), .key_load(key_load),
    .key_main_in(key_main_in), .key_noise_in(key_noise_in),
    .din_valid(din_valid), .din(din), .dout_valid(dout_valid),
    .dout(dout), .key_clash(key_clash)
  );

  // reference substitution: inverse by search, then affine map
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) r ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
      y = y >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] inv = 0;
    for (int y = 1; y < 256; y++)
      if (ref_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    return inv ^ rotl(inv,1) ^ rotl(inv,2) ^ rotl(inv,3) ^ rotl(inv,4) ^ 8'h63;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic load_keys(input logic [7:0] km, input logic [7:0] kn);
    key_main_in = km; key_noise_in = kn; key_load = 1'b1;
    @(negedge clk);
    key_load = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic v);
    din = b; din_valid = v;
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 dout", dout, 8'h00);
    check("R1 dout_valid", {7'b0, dout_valid}, 8'h00);
    check("R1 key_clash", {7'b0, key_clash}, 8'h01);
  endtask

  task automatic t_main();
    load_keys(8'h2b, 8'h91);
    check("R2 clash cleared after load", {7'b0, key_clash}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b = 8'(8'h2b ^ (i * 8'h35));
      push(b, 1'b1);
      check("R3 valid", {7'b0, dout_valid}, 8'h01);
      check("R3 dout", dout, ref_sbox(b ^ 8'h2b));
    end
    load_keys(8'h00, 8'h01);
    push(8'h00, 1'b1);
    check("R3 sbox(00)", dout, 8'h63);
    push(8'h53, 1'b1);
    check("R3 sbox(53)", dout, 8'hed);
  endtask

  task automatic t_idle();
    push(8'h77, 1'b0);
    check("R4 valid low", {7'b0, dout_valid}, 8'h00);
    check("R4 dout held", dout, 8'hed);
  endtask

  task automatic t_clash();
    load_keys(8'h5a, 8'h5a);
    check("R5 clash high", {7'b0, key_clash}, 8'h01);
    push(8'h12, 1'b1);
    check("R5 valid blocked", {7'b0, dout_valid}, 8'h00);
    check("R5 dout held", dout, 8'hed);
  endtask

  task automatic t_noise_isolation();
    logic [7:0] first;
    load_keys(8'h3c, 8'h11);
    push(8'ha4, 1'b1);
    first = dout;
    check("R6 result with noise key 11", first, ref_sbox(8'ha4 ^ 8'h3c));
    load_keys(8'h3c, 8'hc7);
    push(8'ha4, 1'b1);
    check("R6 result unchanged by noise key", dout, first);
  endtask

  task automatic t_key_range();
    load_keys(8'h10, 8'h00);
    check("R7 noise key 00 accepted", {7'b0, key_clash}, 8'h00);
    push(8'h9e, 1'b1);
    check("R7 dout with noise 00", dout, ref_sbox(8'h9e ^ 8'h10));
    load_keys(8'h10, 8'hff);
    check("R7 noise key ff accepted", {7'b0, key_clash}, 8'h00);
    push(8'h01, 1'b1);
    check("R7 dout with noise ff", dout, ref_sbox(8'h01 ^ 8'h10));
  endtask

  task automatic t_load_timing();
    key_main_in = 8'hc3; key_noise_in = 8'h44; key_load = 1'b1;
    din = 8'h66; din_valid = 1'b1;
    @(negedge clk);
    key_load = 1'b0; din_valid = 1'b0;
    check("R2 same-edge byte uses old key", dout, ref_sbox(8'h66 ^ 8'h10));
    push(8'h66, 1'b1);
    check("R2 next byte uses new key", dout, ref_sbox(8'h66 ^ 8'hc3));
    key_main_in = 8'h00; key_noise_in = 8'h00;
    push(8'h66, 1'b1);
    check("R2 keys kept without load", dout, ref_sbox(8'h66 ^ 8'hc3));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_main();
    t_idle();
    t_clash();
    t_noise_isolation();
    t_key_range();
    t_load_timing();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule